// File: doc/BRIEF.md
# Symmetric Dual-Slope PWM Timer Channel

This block is an up/down timer with one compare output that produces a centre-aligned (phase-correct) pulse-width waveform. A free-running prescaler turns the system clock into a count-enable strobe at one of seven division rates. On every strobe the count climbs by one from zero (BOTTOM) to a ceiling (TOP) and then falls back to zero. The ceiling is either the full 8-bit range or the compare value itself. Because the ramp goes up and then down, the pulse sits centred in the period, and a change of duty cycle never shifts its midpoint.

The pin responds to compare events: it falls when the count meets the compare value on the way up and rises when the count meets it on the way down. A polarity input inverts this. At both turning points the pin is also forced to the level the coming slope must start from. This repairs any event that was skipped, so the waveform stays mirror-symmetric around BOTTOM. The compare value is double-buffered and only takes effect at TOP. One-cycle strobes report the arrival at BOTTOM and every compare hit. An enable input gates the waveform onto the pin.

Top module: `pwm_dual_slope`

## Requirements
- R1: While `rst` is high (synchronous), `count` is 0, `pwm_out`, `ovf_pulse` and `match_pulse` are 0 regardless of `invert`. The first count step after reset goes upward.
- R2: On count-enable strobes the count runs 0,1,…,TOP,TOP-1,…,1,0,1,…. TOP and 0 each occur once per turn, so one period is 2·TOP strobes (510 with the full ceiling).
- R3: `presc_sel` sets the strobe rate. The codes 0..7 give: stopped, 1, 8, 32, 64, 128, 256 and 1024 clocks per strobe. The count changes only on strobes. After reset the first strobe falls on clock N, where N is the selected rate.
- R4: With `top_from_cmp` = 0, TOP is 255. With `top_from_cmp` = 1, TOP is the compare value currently in force.
- R5: With `invert` = 0, the pin goes low when the count reaches the compare value on an upward step and goes high when it reaches it on a downward step.
- R6: With `invert` = 1, every level of R5, R7, R8 and R9 is inverted.
- R7: A compare value of 0 holds the non-inverted pin low for the whole period. A compare value equal to TOP holds it high for the whole period.
- R8: On arriving at 0, the pin takes the start-of-slope level: high if the compare in force is nonzero, low if it is zero. This applies whether or not a compare event happens there.
- R9: On arriving at TOP, the pin goes high if the newly loaded compare value is at least TOP, and low otherwise.
- R10: `cmp_val` is copied into the compare in force only on the strobe that reaches TOP, or on any strobe while TOP is 0. Until then the previous value governs the events. Its reset value is 0.
- R11: With `out_en` = 0, `pwm_out` is 0 in the same cycle, while the count keeps running.
- R12: `ovf_pulse` is high for one cycle after the strobe that reaches 0 from above. `match_pulse` is high for one cycle after any strobe whose new count equals the compare in force before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_sel | input | 3 | Strobe-rate code (R3) |
| cmp_val | input | 8 | Compare value, buffered until TOP |
| top_from_cmp | input | 1 | 0: ceiling 255, 1: ceiling from compare |
| invert | input | 1 | Output polarity, 1 = inverted |
| out_en | input | 1 | Gates the waveform onto the pin |
| count | output | 8 | Current count value |
| pwm_out | output | 1 | Waveform pin |
| ovf_pulse | output | 1 | One-cycle strobe at BOTTOM |
| match_pulse | output | 1 | One-cycle strobe on a compare hit |

## Verification
The hardest case is a pin level that is wrong when the count turns at BOTTOM. Compare updates only land at TOP and matches are never skipped, so this state cannot be reached by changing the compare value alone. The bench creates it by flipping the polarity partway down a falling slope, just after the down-count match. This leaves a stale level that no compare event will correct, and the bench then watches for the forced edge on the exact BOTTOM clock. The forced edge at TOP is reached by moving the compare from its maximum to a mid value partway up a rising slope. The old value must keep governing until TOP, where the pin must drop without a match.

// File: rtl/pwm_dual_slope_pkg.sv
package pwm_dual_slope_pkg;
   localparam int unsigned PSEL_W   = 3;
   localparam int unsigned PSEL_NUM = 1 << PSEL_W;
   localparam int unsigned PRE_MIN  = 10;

   function automatic int unsigned presc_shift(input int unsigned code);
      case (code)
         1: return 0;
         2: return 3;
         3: return 5;
         4: return 6;
         5: return 7;
         6: return 8;
         7: return 10;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_dual_slope_pkg::*;
#(
   parameter int unsigned PRE_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PSEL_W-1:0] sel,
   output logic              tick
);
   if (PRE_W < PRE_MIN) begin : g_bad_width
      $error("pwm_prescaler: PRE_W too small for the slowest rate");
   end

   logic [PRE_W-1:0]    pre_q;
   logic [PSEL_NUM-1:0] hit;

   always_ff @(posedge clk) begin
      if (rst) pre_q <= '0;
      else     pre_q <= pre_q + PRE_W'(1);
   end

   assign hit[0] = 1'b0;
   for (genvar i = 1; i < PSEL_NUM; i++) begin : g_tap
      localparam int unsigned SH = presc_shift(i);
      localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << SH) - 64'd1);
      assign hit[i] = ((pre_q & MASK) == MASK);
   end

   assign tick = hit[sel];

   // Back-to-back strobes only at the undivided rate
   assert_consec_tick_R3: assert property (@(posedge clk) disable iff (rst)
      (tick && $past(tick) && sel == $past(sel)) |-> sel == PSEL_W'(1));
endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             dir_nxt,
   output logic             arr_top,
   output logic             arr_bot
);
   if (CNT_W < 2) begin : g_bad_width
      $error("pwm_updown_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic dir_up;

   always_comb begin
      cnt_nxt = cnt;
      dir_nxt = dir_up;
      if (dir_up) begin
         if (cnt >= top) begin
            cnt_nxt = (cnt == '0) ? cnt : cnt - ONE;
            dir_nxt = 1'b0;
         end else begin
            cnt_nxt = cnt + ONE;
         end
      end else begin
         if (cnt == '0) begin
            cnt_nxt = (top == '0) ? cnt : ONE;
            dir_nxt = 1'b1;
         end else begin
            cnt_nxt = cnt - ONE;
         end
      end
   end

   assign arr_top = dir_up && (cnt < top) && (cnt_nxt == top);
   assign arr_bot = !dir_up && (cnt == ONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else if (tick) begin
         cnt    <= cnt_nxt;
         dir_up <= dir_nxt;
      end
   end

   // Count frozen between strobes
   assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt));
endmodule

// File: rtl/pwm_wave_unit.sv
module pwm_wave_unit #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             dir_nxt,
   input  logic             arr_top,
   input  logic             arr_bot,
   input  logic [CNT_W-1:0] top,
   input  logic [CNT_W-1:0] cmp_in,
   input  logic             inv,
   output logic [CNT_W-1:0] ocr_act,
   output logic             wave,
   output logic             ovf,
   output logic             hit
);
   logic             load;
   logic [CNT_W-1:0] ocr_nxt;
   logic             ev;
   logic             lvl;

   assign load    = tick && (arr_top || top == '0);
   assign ocr_nxt = load ? cmp_in : ocr_act;

   always_comb begin
      ev  = 1'b0;
      lvl = 1'b0;
      if (arr_top) begin
         ev  = 1'b1;
         lvl = (ocr_nxt >= top);
      end else if (arr_bot) begin
         ev  = 1'b1;
         lvl = (ocr_act != '0);
      end else if (cnt_nxt == ocr_act) begin
         ev  = 1'b1;
         lvl = !dir_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ocr_act <= '0;
         wave    <= 1'b0;
         ovf     <= 1'b0;
         hit     <= 1'b0;
      end else begin
         ovf <= tick && arr_bot;
         hit <= tick && (cnt_nxt == ocr_act);
         if (load)      ocr_act <= cmp_in;
         if (tick && ev) wave   <= lvl ^ inv;
      end
   end

   assert_bottom_level_R8: assert property (@(posedge clk) disable iff (rst)
      (tick && arr_bot) |=> wave == (($past(ocr_act) != '0) ^ $past(inv)));

   assert_top_level_R9: assert property (@(posedge clk) disable iff (rst)
      (tick && arr_top) |=> wave == ((ocr_act >= $past(top)) ^ $past(inv)));
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
   import pwm_dual_slope_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PRE_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PSEL_W-1:0] presc_sel,
   input  logic [CNT_W-1:0]  cmp_val,
   input  logic              top_from_cmp,
   input  logic              invert,
   input  logic              out_en,
   output logic [CNT_W-1:0]  count,
   output logic              pwm_out,
   output logic              ovf_pulse,
   output logic              match_pulse
);
   localparam logic [CNT_W-1:0] TOP_MAX = '1;

   logic             tick;
   logic [CNT_W-1:0] top;
   logic [CNT_W-1:0] cnt_nxt;
   logic             dir_nxt;
   logic             arr_top;
   logic             arr_bot;
   logic [CNT_W-1:0] ocr_act;
   logic             wave;

   assign top = top_from_cmp ? ocr_act : TOP_MAX;

   pwm_prescaler #(.PRE_W(PRE_W)) u_presc (
      .clk (clk),
      .rst (rst),
      .sel (presc_sel),
      .tick(tick)
   );

   pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .top    (top),
      .cnt    (count),
      .cnt_nxt(cnt_nxt),
      .dir_nxt(dir_nxt),
      .arr_top(arr_top),
      .arr_bot(arr_bot)
   );

   pwm_wave_unit #(.CNT_W(CNT_W)) u_wave (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .cnt_nxt(cnt_nxt),
      .dir_nxt(dir_nxt),
      .arr_top(arr_top),
      .arr_bot(arr_bot),
      .top    (top),
      .cmp_in (cmp_val),
      .inv    (invert),
      .ocr_act(ocr_act),
      .wave   (wave),
      .ovf    (ovf_pulse),
      .hit    (match_pulse)
   );

   assign pwm_out = out_en & wave;

   assert_ovf_at_bottom_R12: assert property (@(posedge clk) disable iff (rst)
      ovf_pulse |-> (count == '0));

   assert_ovf_single_R12: assert property (@(posedge clk) disable iff (rst)
      ovf_pulse |=> !ovf_pulse);

   assert_load_at_top_R10: assert property (@(posedge clk) disable iff (rst)
      (!$stable(ocr_act) && !top_from_cmp && !$past(top_from_cmp)) |-> (count == TOP_MAX));
endmodule

// File: tb/pwm_dual_slope_tb.sv
module pwm_dual_slope_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] presc_sel = 3'd1;
   logic [7:0] cmp_val = 8'd0;
   logic       top_from_cmp = 1'b0;
   logic       invert = 1'b0;
   logic       out_en = 1'b1;
   logic [7:0] count;
   logic       pwm_out, ovf_pulse, match_pulse;

   int tests = 0;
   int fails = 0;
   int c = 0;

   always #4 clk = ~clk;

   pwm_dual_slope u_dut (
      .clk(clk), .rst(rst), .presc_sel(presc_sel), .cmp_val(cmp_val),
      .top_from_cmp(top_from_cmp), .invert(invert), .out_en(out_en),
      .count(count), .pwm_out(pwm_out), .ovf_pulse(ovf_pulse),
      .match_pulse(match_pulse)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, c, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      c++;
   endtask

   task automatic run_to(input int n);
      while (c < n) step();
   endtask

   task automatic do_reset(input int sel, input int k, input bit mode_a,
                           input bit inv, input bit en);
      @(negedge clk);
      rst = 1'b1;
      presc_sel = 3'(sel);
      cmp_val = 8'(k);
      top_from_cmp = mode_a;
      invert = inv;
      out_en = en;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      c = 0;
   endtask

   function automatic int tri_cnt(input int cc);
      int n = cc % 510;
      return (n <= 255) ? n : 510 - n;
   endfunction

   function automatic int exp_lvl(input int cc, input int k);
      int n = cc % 510;
      int v = (n <= 255) ? n : 510 - n;
      if (k == 0) return 0;
      if (v < k) return 1;
      if (v == k && n > 255) return 1;
      if (v == 255 && k >= 255) return 1;
      return 0;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      invert = 1'b1;
      out_en = 1'b1;
      presc_sel = 3'd1;
      cmp_val = 8'd77;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 count", count, 0);
      chk("R1 pin", pwm_out, 0);
      chk("R1 ovf", ovf_pulse, 0);
      chk("R1 match", match_pulse, 0);
      rst = 1'b0;
      c = 0;
      step();
      chk("R1 first step up", count, 1);
   endtask

   task automatic t_count();
      do_reset(1, 100, 0, 0, 1);
      for (int i = 1; i <= 1100; i++) begin
         step();
         chk("R2 triangle", count, tri_cnt(c));
      end
   endtask

   task automatic t_wave(input string req, input int k, input bit inv);
      do_reset(1, k, 0, inv, 1);
      run_to(254);
      for (int i = 255; i <= 1275; i++) begin
         step();
         chk(req, pwm_out, exp_lvl(c, k) ^ int'(inv));
      end
   endtask

   task automatic t_presc();
      do_reset(2, 0, 0, 0, 1);
      run_to(7);   chk("R3 div8", count, 0);
      run_to(8);   chk("R3 div8", count, 1);
      run_to(15);  chk("R3 div8", count, 1);
      run_to(16);  chk("R3 div8", count, 2);
      run_to(100); chk("R3 div8", count, 12);
      do_reset(3, 0, 0, 0, 1);
      run_to(31);  chk("R3 div32", count, 0);
      run_to(32);  chk("R3 div32", count, 1);
      do_reset(7, 0, 0, 0, 1);
      run_to(1023); chk("R3 div1024", count, 0);
      run_to(1024); chk("R3 div1024", count, 1);
      run_to(3072); chk("R3 div1024", count, 3);
      do_reset(0, 0, 0, 0, 1);
      run_to(60);  chk("R3 stopped", count, 0);
   endtask

   task automatic t_mode_a();
      int peak = 0;
      do_reset(1, 50, 1, 0, 1);
      step(); chk("R4 hold at zero", count, 0);
      step(); chk("R4 climb", count, 1);
      run_to(51); chk("R4 top from compare", count, 50);
      step(); chk("R4 turn at top", count, 49);
      run_to(101); chk("R4 bottom", count, 0);
      chk("R12 ovf mode A", ovf_pulse, 1);
      while (c < 300) begin
         step();
         if (count > peak) peak = count;
      end
      chk("R4 ceiling", peak, 50);
   endtask

   task automatic t_bottom_force();
      do_reset(1, 100, 0, 0, 1);
      run_to(460); chk("R8 high before flip", pwm_out, 1);
      invert = 1'b1;
      run_to(509); chk("R8 stale level kept", pwm_out, 1);
      step();      chk("R8 forced edge at bottom", pwm_out, 0);
      run_to(610); chk("R6 inverted up match", pwm_out, 1);
   endtask

   task automatic t_top_force();
      do_reset(1, 255, 0, 0, 1);
      run_to(600); chk("R7 max high", pwm_out, 1);
      cmp_val = 8'd100;
      run_to(764); chk("R10 old compare governs", pwm_out, 1);
      step();      chk("R9 forced edge at top", pwm_out, 0);
      run_to(920); chk("R5 down match new value", pwm_out, 1);
   endtask

   task automatic t_buffer();
      do_reset(1, 100, 0, 0, 1);
      run_to(300);
      cmp_val = 8'd200;
      run_to(409); chk("R12 no match", match_pulse, 0);
      step();      chk("R10 old value match", match_pulse, 1);
      chk("R5 set on down match", pwm_out, 1);
      step();      chk("R12 one cycle", match_pulse, 0);
      run_to(710); chk("R10 new value not yet", match_pulse, 0);
      run_to(820); chk("R10 new value after top", match_pulse, 1);
   endtask

   task automatic t_ovf();
      do_reset(1, 100, 0, 0, 1);
      run_to(509); chk("R12 ovf before", ovf_pulse, 0);
      step();      chk("R12 ovf at bottom", ovf_pulse, 1);
      step();      chk("R12 ovf one cycle", ovf_pulse, 0);
      run_to(1020); chk("R12 ovf second", ovf_pulse, 1);
   endtask

   task automatic t_enable();
      do_reset(1, 100, 0, 0, 0);
      run_to(560);
      chk("R11 pin gated", pwm_out, 0);
      chk("R11 count runs", count, 50);
      out_en = 1'b1;
      #1;
      chk("R11 pin at once", pwm_out, 1);
      step();
      chk("R11 pin follows", pwm_out, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_count();
      t_wave("R5 non-inverted", 100, 1'b0);
      t_wave("R6 inverted", 100, 1'b1);
      t_wave("R7 compare zero", 0, 1'b0);
      t_wave("R7 compare max", 255, 1'b0);
      t_wave("R5 compare one", 1, 1'b0);
      t_wave("R5 compare 254", 254, 1'b0);
      t_presc();
      t_mode_a();
      t_bottom_force();
      t_top_force();
      t_buffer();
      t_ovf();
      t_enable();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule